// File: doc/BRIEF.md
# Dual-Storage Mealy Sequence Recognizer

This block is a clocked Mealy machine with one serial input bit and one output bit. It holds two state bits, called y1 and y2. On every rising clock edge it takes the serial bit and moves to a new state. Its output depends on the present state and on the present input bit, so the output is combinational in the input.

The same machine is built twice inside the block, and both copies run in parallel:

- The first copy holds its state in plain D registers.
- The second copy holds its state in JK storage elements. These elements are synchronous and are driven by their own excitation equations.

A registered flag compares the two copies every cycle. It rises whenever their states or their outputs disagree, which gives a cycle-by-cycle cross-check of the two realizations.

The block is used as a pattern detector on a bit stream. It also serves as a self-checking example of one state table realized with two kinds of storage.

Top module: `seq_recog_dual`

## Requirements
- R1: While the synchronous active-high reset is sampled high at a rising edge, the state after that edge is 00 (`stateOut` = 2'b00, bit 1 = y1, bit 0 = y2) and `mismatch` is 0.
- R2: `zOut` is 1 exactly when the state is 01 with input 1, or when the state is 10 with input 0. For every other state and input pair it is 0.
- R3: From state 00, input 0 leads to 00 and input 1 leads to 01.
- R4: From state 01, input 0 leads to 00 and input 1 leads to 11.
- R5: From state 10, input 0 leads to 11 and input 1 leads to 10.
- R6: From state 11, input 0 leads to 01 and input 1 leads to 10.
- R7: The D-storage copy and the JK-storage copy always agree, so `mismatch` stays 0 after reset on a correct design. The flag is registered: it reports the comparison made at the previous rising edge.
- R8: `zOut` follows a change of `xIn` within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| xIn | input | 1 | Serial input bit |
| zOut | output | 1 | Mealy output (D-storage copy) |
| stateOut | output | 2 | Present state {y1, y2} of the D-storage copy |
| mismatch | output | 1 | Registered disagreement flag between the two copies |

## Verification
The output `zOut` is due in the same cycle as the input bit. The bench therefore samples it a moment after driving `xIn`, with no clock edge in between. It samples it again after a mid-cycle change of `xIn`.

The next state is due one rising edge after the bit is applied, and `mismatch` is due after the same single register stage. The scoreboard monitor checks both of these two time units after that edge, well before the driver's next falling-edge update.

// File: rtl/mealy_pkg.sv
package mealy_pkg;
  localparam int STATE_W = 2;
  typedef logic [STATE_W-1:0] state_t;

  localparam state_t ST_00 = 2'b00;
  localparam state_t ST_01 = 2'b01;
  localparam state_t ST_10 = 2'b10;
  localparam state_t ST_11 = 2'b11;

  // Strobes from the excitation logic to the storage datapath.
  typedef struct packed {
    state_t dIn;  // D-storage next state
    state_t jIn;  // JK set strobes
    state_t kIn;  // JK reset strobes
  } excite_t;
endpackage

// File: rtl/jk_cell.sv
module jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic jIn,
  input  logic kIn,
  output logic qOut
);
  always_ff @(posedge clk) begin
    if (rst) begin
      qOut <= 1'b0;
    end else begin
      unique case ({jIn, kIn})
        2'b00:   qOut <= qOut;
        2'b01:   qOut <= 1'b0;
        2'b10:   qOut <= 1'b1;
        default: qOut <= ~qOut;
      endcase
    end
  end
endmodule

// File: rtl/seq_excite.sv
module seq_excite
  import mealy_pkg::*;
(
  input  logic    xIn,
  input  state_t  stD,
  input  state_t  stJ,
  output excite_t exc
);
  logic dY1, dY2, jY1, jY2;

  assign dY1 = stD[1];
  assign dY2 = stD[0];
  assign jY1 = stJ[1];
  assign jY2 = stJ[0];

  always_comb begin
    // D realization
    exc.dIn[1] = (dY1 & ~dY2) | (xIn & dY2);
    exc.dIn[0] = (~xIn & dY1) | (xIn & ~dY1);
    // JK realization
    exc.jIn[1] = xIn & jY2;
    exc.kIn[1] = ~xIn & jY2;
    exc.jIn[0] = (xIn & ~jY1) | (~xIn & jY1);
    exc.kIn[0] = (xIn & jY1) | (~xIn & ~jY1);
  end

  // Each bit: J and K never both high for bit 0 (they are complements)
  always_comb begin
    if (!$isunknown(stJ)) begin
      assert ($countones({exc.jIn[0], exc.kIn[0]}) == 1)
        else $error("p_jk_bit0_exclusive_r7");
    end
  end
endmodule

// File: rtl/seq_store.sv
module seq_store
  import mealy_pkg::*;
#(
  parameter bit STICKY_MISMATCH = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    xIn,
  input  excite_t exc,
  output state_t  stD,
  output state_t  stJ,
  output logic    zD,
  output logic    mismatch
);
  logic zJ;
  logic diffNow;

  always_ff @(posedge clk) begin
    if (rst) stD <= ST_00;
    else     stD <= exc.dIn;
  end

  genvar b;
  generate
    for (b = 0; b < STATE_W; b++) begin : g_jk
      jk_cell u_cell (
        .clk  (clk),
        .rst  (rst),
        .jIn  (exc.jIn[b]),
        .kIn  (exc.kIn[b]),
        .qOut (stJ[b])
      );
    end
  endgenerate

  assign zD = (xIn & ~stD[1] & stD[0]) | (~xIn & stD[1] & ~stD[0]);
  assign zJ = (xIn & ~stJ[1] & stJ[0]) | (~xIn & stJ[1] & ~stJ[0]);
  assign diffNow = (stD != stJ) || (zD != zJ);

  generate
    if (STICKY_MISMATCH) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst) mismatch <= 1'b0;
        else     mismatch <= mismatch | diffNow;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) mismatch <= 1'b0;
        else     mismatch <= diffNow;
      end
    end
  endgenerate

  p_reset_state_r1: assert property (@(posedge clk) rst |=> (stD == ST_00 && stJ == ST_00));
  p_copies_agree_r7: assert property (@(posedge clk) disable iff (rst) stD == stJ);
  p_z_table_r2: assert property (@(posedge clk) disable iff (rst)
    zD == ((stD == ST_01 && xIn) || (stD == ST_10 && !xIn)));
  p_step_01_r4: assert property (@(posedge clk) disable iff (rst)
    (stD == ST_01 && xIn) |=> stD == ST_11);
  p_step_10_r5: assert property (@(posedge clk) disable iff (rst)
    (stD == ST_10 && !xIn) |=> stD == ST_11);
  p_step_11_r6: assert property (@(posedge clk) disable iff (rst)
    (stD == ST_11 && !xIn) |=> stD == ST_01);
  p_step_00_r3: assert property (@(posedge clk) disable iff (rst)
    (stD == ST_00 && !xIn) |=> $stable(stD));
endmodule

// File: rtl/seq_recog_dual.sv
module seq_recog_dual
  import mealy_pkg::*;
#(
  parameter bit STICKY_MISMATCH = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xIn,
  output logic       zOut,
  output logic [1:0] stateOut,
  output logic       mismatch
);
  excite_t exc;
  state_t  stD, stJ;

  seq_excite u_excite (
    .xIn (xIn),
    .stD (stD),
    .stJ (stJ),
    .exc (exc)
  );

  seq_store #(.STICKY_MISMATCH(STICKY_MISMATCH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .xIn      (xIn),
    .exc      (exc),
    .stD      (stD),
    .stJ      (stJ),
    .zD       (zOut),
    .mismatch (mismatch)
  );

  assign stateOut = stD;
endmodule

// File: tb/test_seq_recog_dual.sv
module test_seq_recog_dual;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xIn = 1'b0;
  logic       zOut;
  logic [1:0] stateOut;
  logic       mismatch;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic       zExp;
    logic [1:0] nextExp;
    string      tag;
  } item_t;
  item_t q[$];

  logic [1:0] model = 2'b00;

  always #10 clk = ~clk;  // 50 MHz

  seq_recog_dual i_seq_recog_dual (
    .clk      (clk),
    .rst      (rst),
    .xIn      (xIn),
    .zOut     (zOut),
    .stateOut (stateOut),
    .mismatch (mismatch)
  );

  function automatic logic [1:0] refNext(logic [1:0] s, logic x);
    case (s)
      2'b00:   return x ? 2'b01 : 2'b00;
      2'b01:   return x ? 2'b11 : 2'b00;
      2'b10:   return x ? 2'b10 : 2'b11;
      default: return x ? 2'b10 : 2'b01;
    endcase
  endfunction

  function automatic logic refZ(logic [1:0] s, logic x);
    return (s == 2'b01 && x) || (s == 2'b10 && !x);
  endfunction

  function automatic string fromTag(logic [1:0] s);
    case (s)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic applyBit(logic b);
    item_t it;
    @(negedge clk);
    xIn = b;
    it.zExp    = refZ(model, b);
    it.nextExp = refNext(model, b);
    it.tag     = fromTag(model);
    model      = it.nextExp;
    q.push_back(it);
  endtask

  // R8: flip xIn mid-cycle, z must follow without a clock edge
  task automatic flipWithinCycle(logic first);
    item_t it;
    @(negedge clk);
    xIn = first;
    #2;
    check("R8", {1'b0, zOut}, {1'b0, refZ(model, first)});
    xIn = ~first;
    it.zExp    = refZ(model, ~first);
    it.nextExp = refNext(model, ~first);
    it.tag     = fromTag(model);
    model      = it.nextExp;
    q.push_back(it);
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      #1;
      check("R2", {1'b0, zOut}, {1'b0, it.zExp});
      @(posedge clk);
      #2;
      check(it.tag, stateOut, it.nextExp);
      check("R7", {1'b0, mismatch}, 2'b00);
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(posedge clk);
    #2;
    check("R1", stateOut, 2'b00);
    check("R1", {1'b0, mismatch}, 2'b00);
    @(negedge clk);
    rst = 1'b0;

    // directed walk covering every state/input pair
    applyBit(1); applyBit(1); applyBit(1); applyBit(1);
    applyBit(0); applyBit(0); applyBit(0); applyBit(0);

    // combinational response inside one cycle
    applyBit(1);          // 00 -> 01
    flipWithinCycle(0);   // at 01: x=0 then 1 -> 11
    applyBit(1);          // 11 -> 10
    flipWithinCycle(1);   // at 10: x=1 then 0 -> 11

    // pseudo-random stream
    lfsr = 8'hA5;
    for (int i = 0; i < 60; i++) begin
      applyBit(lfsr[0]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    // mid-run reset from a non-zero state
    applyBit(1); applyBit(1);   // lands in a state reached via 01 or beyond
    wait (q.size() == 0);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1", stateOut, 2'b00);
    check("R1", {1'b0, mismatch}, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    model = 2'b00;
    applyBit(0);
    applyBit(1);
    wait (q.size() == 0);
    @(posedge clk);
    #5;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule